// File: doc/BRIEF.md
# Bus Ownership Handoff Controller

This controller moves ownership of a shared, open-collector style data transfer bus from one master to the next without a glitch on the address strobe. When the local master is the outgoing owner, it starts the release once the final transfer is under way with the address strobe asserted. It raises a request to drop the bus-busy line. Once that transfer has been acknowledged, it turns off every driver except the address strobe, which stays low for one cycle. It then either lets go of the strobe at once or parks it high for a programmable number of cycles before letting go.

When the local master is the incoming owner, it waits for a grant and for the strobe line to read high. It then switches on its address and control drivers, plus its strobe driver held high, and leaves the data drivers off. It counts an address setup window before anything else happens. If the first cycle will be a write, it also waits until the acknowledge and bus error lines both read high. Only after all of this does it raise `bus_owned`. That signal gates the start of the master cycle sequencer, and it also gates the sequencer's requests to drive the strobe low and to drive data.

Bus lines are seen as levels (1 = line high). Driver enables are active high, and `as_drive` is the level placed on the strobe while `as_oe` is set.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: While `rst_n` is low: `ctl_oe`, `as_oe`, `data_oe`, `busy_rel` and `bus_owned` are 0 and `as_drive` is 1.
- R2: With `grant_in` high and the controller idle, `ctl_oe` stays 0 in every cycle in which `as_line` was sampled low. It rises on the clock edge that samples `as_line` high.
- R3: On acquisition `ctl_oe` and `as_oe` rise together with `as_drive` = 1. `data_oe` and `bus_owned` stay 0 while setup runs, whatever `seq_data_oe` is.
- R4: During the SETUP_CYCLES clock cycles that start when `ctl_oe` rises, `as_drive` stays 1 even if `seq_as_low` is 1. For a read first cycle, `bus_owned` rises on the edge that ends that window.
- R5: For a write first cycle (`first_is_write` = 1), `bus_owned` does not rise while `dtack_line` or `berr_line` is sampled low. It rises on the first edge after setup that samples both lines high.
- R6: `data_oe` equals `bus_owned` AND `seq_data_oe`.
- R7: While `bus_owned` is 1, `as_oe` is 1, `ctl_oe` is 1 and `as_drive` equals NOT `seq_as_low`.
- R8: `busy_rel` rises on the edge that samples `final_xfer_started` = 1 together with `seq_as_low` = 1 while owned. `final_xfer_started` sampled with `seq_as_low` = 0 has no effect. `busy_rel` stays 1 until the strobe driver is released.
- R9: On the edge that samples `last_ack` = 1 while `busy_rel` is 1, `ctl_oe`, `data_oe` and `bus_owned` drop to 0. In that same cycle `as_oe` stays 1 with `as_drive` = 0, for exactly one cycle.
- R10: If `as_park_high` is 0 when that one cycle ends, `as_oe` and `busy_rel` fall on the next edge.
- R11: If `as_park_high` is 1, `as_drive` becomes 1 with `as_oe` held for PARK_CYCLES cycles. Then `as_oe` and `busy_rel` fall.
- R12: `grant_in` is ignored while the controller owns or is releasing the bus.
- R13: The strobe is never driven low together with the control drivers before SETUP_CYCLES cycles of driver enable have passed. The strobe driver is never dropped while driven low with the control drivers on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_in | input | 1 | Bus grant from arbitration |
| as_line | input | 1 | Sensed address strobe line level |
| dtack_line | input | 1 | Sensed transfer acknowledge line level |
| berr_line | input | 1 | Sensed bus error line level |
| first_is_write | input | 1 | First cycle after acquisition is a write |
| seq_as_low | input | 1 | Cycle sequencer requests strobe low |
| seq_data_oe | input | 1 | Cycle sequencer requests data drivers |
| final_xfer_started | input | 1 | Final transfer of this tenure has begun |
| last_ack | input | 1 | Final transfer acknowledged |
| as_park_high | input | 1 | Release mode: park strobe high before release |
| ctl_oe | output | 1 | Address and control driver enable |
| as_oe | output | 1 | Address strobe driver enable |
| as_drive | output | 1 | Level driven on the address strobe |
| data_oe | output | 1 | Data driver enable |
| busy_rel | output | 1 | Request to release the bus-busy line |
| bus_owned | output | 1 | Ownership established, sequencer may start |

## Verification
The bench sweeps both first-cycle directions, both release modes, several delays before the strobe reads high and several delays before the acknowledge line clears. A design that enabled drivers before the strobe read high would collide with the outgoing owner. One that counted setup one cycle short would let the sequencer pull the strobe low too early, and the bench catches this with `seq_as_low` held high across the whole window. A design that enabled data on a write without waiting would fight the previous slave. In release, the bench checks the single strobe-low cycle, the exact park length and that `busy_rel` drops together with the strobe. It also checks that a stray grant and a final-transfer flag with the strobe high change nothing.

// File: rtl/handoff_pkg.sv
package handoff_pkg;

  typedef enum logic [1:0] {
    ACQ_IDLE,
    ACQ_WAIT_AS,
    ACQ_SETUP,
    ACQ_WAIT_DATA
  } acq_state_t;

  typedef enum logic [1:0] {
    REL_IDLE,
    REL_OWN,
    REL_HOLD,
    REL_PARK
  } rel_state_t;

endpackage

// File: rtl/handoff_tick_cnt.sv
module handoff_tick_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/handoff_acquire.sv
module handoff_acquire
  import handoff_pkg::*;
#(
  parameter int SETUP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_in,
  input  logic as_line,
  input  logic rel_idle,
  input  logic first_is_write,
  input  logic dtack_line,
  input  logic berr_line,
  output logic acq_drive,
  output logic acq_done
);

  localparam int CW = $clog2(SETUP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETUP_CYCLES - 1);

  acq_state_t   state_q, state_d;
  logic [CW-1:0] cnt;
  logic          in_setup;
  logic          lines_idle;

  assign in_setup   = (state_q == ACQ_SETUP);
  assign lines_idle = dtack_line & berr_line;

  handoff_tick_cnt #(.W(CW)) u_setup_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_setup),
    .en    (in_setup),
    .cnt   (cnt)
  );

  always_comb begin
    state_d  = state_q;
    acq_done = 1'b0;
    unique case (state_q)
      ACQ_IDLE: begin
        if (grant_in && rel_idle) state_d = as_line ? ACQ_SETUP : ACQ_WAIT_AS;
      end
      ACQ_WAIT_AS: begin
        if (!grant_in)    state_d = ACQ_IDLE;
        else if (as_line) state_d = ACQ_SETUP;
      end
      ACQ_SETUP: begin
        if (cnt == LAST) begin
          if (first_is_write && !lines_idle) begin
            state_d = ACQ_WAIT_DATA;
          end else begin
            state_d  = ACQ_IDLE;
            acq_done = 1'b1;
          end
        end
      end
      ACQ_WAIT_DATA: begin
        if (lines_idle) begin
          state_d  = ACQ_IDLE;
          acq_done = 1'b1;
        end
      end
      default: state_d = ACQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACQ_IDLE;
    else        state_q <= state_d;
  end

  assign acq_drive = (state_q == ACQ_SETUP) || (state_q == ACQ_WAIT_DATA);

endmodule

// File: rtl/handoff_release.sv
module handoff_release
  import handoff_pkg::*;
#(
  parameter int PARK_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_done,
  input  logic seq_as_low,
  input  logic final_xfer_started,
  input  logic last_ack,
  input  logic as_park_high,
  output logic rel_idle,
  output logic owned,
  output logic as_en,
  output logic as_lvl,
  output logic busy_rel
);

  localparam int CW = $clog2(PARK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PARK_CYCLES - 1);

  rel_state_t    state_q, state_d;
  logic          final_q, final_d;
  logic [CW-1:0] cnt;
  logic          in_park;

  assign in_park = (state_q == REL_PARK);

  handoff_tick_cnt #(.W(CW)) u_park_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_park),
    .en    (in_park),
    .cnt   (cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      REL_IDLE: if (acq_done)             state_d = REL_OWN;
      REL_OWN:  if (final_q && last_ack)  state_d = REL_HOLD;
      REL_HOLD: state_d = as_park_high ? REL_PARK : REL_IDLE;
      REL_PARK: if (cnt == LAST)          state_d = REL_IDLE;
      default:  state_d = REL_IDLE;
    endcase
  end

  always_comb begin
    final_d = final_q;
    if (state_q == REL_OWN && final_xfer_started && seq_as_low) final_d = 1'b1;
    if (state_d == REL_IDLE) final_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= REL_IDLE;
      final_q <= 1'b0;
    end else begin
      state_q <= state_d;
      final_q <= final_d;
    end
  end

  always_comb begin
    as_lvl = 1'b1;
    unique case (state_q)
      REL_OWN:  as_lvl = !seq_as_low;
      REL_HOLD: as_lvl = 1'b0;
      default:  as_lvl = 1'b1;
    endcase
  end

  assign rel_idle = (state_q == REL_IDLE);
  assign owned    = (state_q == REL_OWN);
  assign as_en    = !rel_idle;
  assign busy_rel = final_q;

endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl #(
  parameter int SETUP_CYCLES = 4,
  parameter int PARK_CYCLES  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_in,
  input  logic as_line,
  input  logic dtack_line,
  input  logic berr_line,
  input  logic first_is_write,
  input  logic seq_as_low,
  input  logic seq_data_oe,
  input  logic final_xfer_started,
  input  logic last_ack,
  input  logic as_park_high,
  output logic ctl_oe,
  output logic as_oe,
  output logic as_drive,
  output logic data_oe,
  output logic busy_rel,
  output logic bus_owned
);

  logic acq_drive, acq_done;
  logic rel_idle, owned, rel_as_en, rel_as_lvl;

  handoff_acquire #(.SETUP_CYCLES(SETUP_CYCLES)) u_acq (
    .clk            (clk),
    .rst_n          (rst_n),
    .grant_in       (grant_in),
    .as_line        (as_line),
    .rel_idle       (rel_idle),
    .first_is_write (first_is_write),
    .dtack_line     (dtack_line),
    .berr_line      (berr_line),
    .acq_drive      (acq_drive),
    .acq_done       (acq_done)
  );

  handoff_release #(.PARK_CYCLES(PARK_CYCLES)) u_rel (
    .clk                (clk),
    .rst_n              (rst_n),
    .acq_done           (acq_done),
    .seq_as_low         (seq_as_low),
    .final_xfer_started (final_xfer_started),
    .last_ack           (last_ack),
    .as_park_high       (as_park_high),
    .rel_idle           (rel_idle),
    .owned              (owned),
    .as_en              (rel_as_en),
    .as_lvl             (rel_as_lvl),
    .busy_rel           (busy_rel)
  );

  assign ctl_oe    = acq_drive | owned;
  assign as_oe     = acq_drive | rel_as_en;
  assign as_drive  = rel_as_en ? rel_as_lvl : 1'b1;
  assign data_oe   = owned & seq_data_oe;
  assign bus_owned = owned;

endmodule

// File: rtl/bus_handoff_ctrl_chk.sv
module bus_handoff_ctrl_chk #(
  parameter int SETUP_CYCLES = 4,
  parameter int PARK_CYCLES  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic as_line,
  input logic dtack_line,
  input logic berr_line,
  input logic first_is_write,
  input logic ctl_oe,
  input logic as_oe,
  input logic as_drive,
  input logic data_oe,
  input logic bus_owned
);

  localparam int CW = $clog2(SETUP_CYCLES + 1);

  logic [CW-1:0] en_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          en_cnt <= '0;
    else if (!ctl_oe)                    en_cnt <= '0;
    else if (en_cnt < CW'(SETUP_CYCLES)) en_cnt <= en_cnt + 1'b1;
  end

  // R13: strobe low with control drivers on only after the setup window
  a_r13_as_low_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (as_oe && !as_drive && ctl_oe) |-> (en_cnt >= CW'(SETUP_CYCLES)));

  // R13: strobe driver kept while low and control drivers on
  a_r13_as_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (as_oe && !as_drive && ctl_oe) |=> as_oe);

  a_r2_enable_after_as_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe) |-> $past(as_line));

  a_r7_ctl_with_as: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> as_oe);

  a_r6_data_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> bus_owned);

  a_r5_write_waits_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_owned) && first_is_write) |-> $past(dtack_line && berr_line));

endmodule

bind bus_handoff_ctrl bus_handoff_ctrl_chk #(
  .SETUP_CYCLES (SETUP_CYCLES),
  .PARK_CYCLES  (PARK_CYCLES)
) u_chk (.*);

// File: tb/bus_handoff_ctrl_tb.sv
module bus_handoff_ctrl_tb;

  localparam int SETUP = 4;
  localparam int PARK  = 3;

  logic clk, rst_n;
  logic grant_in, as_line, dtack_line, berr_line, first_is_write;
  logic seq_as_low, seq_data_oe, final_xfer_started, last_ack, as_park_high;
  logic ctl_oe, as_oe, as_drive, data_oe, busy_rel, bus_owned;

  int checks = 0;
  int fails  = 0;

  bus_handoff_ctrl #(.SETUP_CYCLES(SETUP), .PARK_CYCLES(PARK)) u_dut (
    .clk(clk), .rst_n(rst_n), .grant_in(grant_in), .as_line(as_line),
    .dtack_line(dtack_line), .berr_line(berr_line), .first_is_write(first_is_write),
    .seq_as_low(seq_as_low), .seq_data_oe(seq_data_oe),
    .final_xfer_started(final_xfer_started), .last_ack(last_ack),
    .as_park_high(as_park_high), .ctl_oe(ctl_oe), .as_oe(as_oe),
    .as_drive(as_drive), .data_oe(data_oe), .busy_rel(busy_rel),
    .bus_owned(bus_owned)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_handoff(input logic wr, input logic park, input int as_dly, input int ack_dly);
    first_is_write = wr;
    grant_in       = 1'b1;
    as_line        = (as_dly == 0);
    step();
    chk("R2 enable timing", ctl_oe, as_dly == 0);
    for (int i = 1; i <= as_dly; i++) begin
      if (i == as_dly) as_line = 1'b1;
      step();
      chk("R2 wait for strobe high", ctl_oe, i == as_dly);
    end
    // first SETUP cycle
    chk("R3 strobe enable", as_oe, 1'b1);
    chk("R3 strobe high", as_drive, 1'b1);
    seq_as_low  = 1'b1;
    seq_data_oe = 1'b1;
    grant_in    = 1'b0;
    dtack_line  = !(wr && ack_dly > 0);
    #1;
    chk("R3 no data during setup", data_oe, 1'b0);
    chk("R4 strobe held high", as_drive, 1'b1);
    for (int j = 1; j < SETUP; j++) begin
      step();
      chk("R4 not owned in setup", bus_owned, 1'b0);
      chk("R4 strobe held high", as_drive, 1'b1);
    end
    step();
    chk("R4 owned after setup", bus_owned, !(wr && ack_dly > 0));
    for (int k = 1; k <= ack_dly && wr; k++) begin
      if (k == ack_dly) dtack_line = 1'b1;
      step();
      chk("R5 write waits for idle lines", bus_owned, k == ack_dly);
    end
    chk("R7 strobe follows sequencer low", as_drive, 1'b0);
    chk("R6 data enable when owned", data_oe, 1'b1);
    seq_as_low  = 1'b0;
    seq_data_oe = 1'b0;
    #1;
    chk("R7 strobe follows sequencer high", as_drive, 1'b1);
    chk("R6 data follows sequencer", data_oe, 1'b0);
    grant_in = 1'b1;
    final_xfer_started = 1'b1;
    step();
    chk("R12 grant ignored while owned", bus_owned, 1'b1);
    chk("R8 final with strobe high ignored", busy_rel, 1'b0);
    grant_in   = 1'b0;
    seq_as_low = 1'b1;
    step();
    chk("R8 busy release raised", busy_rel, 1'b1);
    final_xfer_started = 1'b0;
    seq_data_oe  = 1'b1;
    last_ack     = 1'b1;
    as_park_high = park;
    step();
    last_ack   = 1'b0;
    seq_as_low = 1'b0;
    #1;
    chk("R9 control released", ctl_oe, 1'b0);
    chk("R9 data released", data_oe, 1'b0);
    chk("R9 ownership dropped", bus_owned, 1'b0);
    chk("R9 strobe still driven", as_oe, 1'b1);
    chk("R9 strobe still low", as_drive, 1'b0);
    seq_data_oe = 1'b0;
    if (park) begin
      for (int p = 1; p <= PARK; p++) begin
        step();
        chk("R11 parked strobe enabled", as_oe, 1'b1);
        chk("R11 parked strobe high", as_drive, 1'b1);
        chk("R11 busy release held", busy_rel, 1'b1);
      end
      step();
      chk("R11 strobe released after park", as_oe, 1'b0);
      chk("R11 busy release cleared", busy_rel, 1'b0);
    end else begin
      step();
      chk("R10 strobe released directly", as_oe, 1'b0);
      chk("R10 busy release cleared", busy_rel, 1'b0);
    end
    step();
  endtask

  initial begin
    rst_n = 1'b0;
    grant_in = 1'b0; as_line = 1'b1; dtack_line = 1'b1; berr_line = 1'b1;
    first_is_write = 1'b0; seq_as_low = 1'b0; seq_data_oe = 1'b0;
    final_xfer_started = 1'b0; last_ack = 1'b0; as_park_high = 1'b0;
    repeat (3) step();
    chk("R1 ctl_oe", ctl_oe, 1'b0);
    chk("R1 as_oe", as_oe, 1'b0);
    chk("R1 as_drive", as_drive, 1'b1);
    chk("R1 data_oe", data_oe, 1'b0);
    chk("R1 busy_rel", busy_rel, 1'b0);
    chk("R1 bus_owned", bus_owned, 1'b0);
    rst_n = 1'b1;
    step();
    for (int wr = 0; wr < 2; wr++)
      for (int pk = 0; pk < 2; pk++)
        for (int ad = 0; ad < 3; ad++)
          for (int kd = 0; kd < 3; kd++)
            run_handoff(wr[0], pk[0], ad * ad, kd);
    // berr low also blocks a write handoff
    berr_line = 1'b0;
    first_is_write = 1'b1;
    grant_in = 1'b1;
    step();
    grant_in = 1'b0;
    repeat (SETUP + 2) step();
    chk("R5 bus error line blocks write", bus_owned, 1'b0);
    berr_line = 1'b1;
    step();
    chk("R5 owned once bus error clears", bus_owned, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule